// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps a record of loads that software has moved ahead of stores that might write the same memory. When such an early load issues, its destination register number, byte address and access size go into a small table. Each store that executes afterwards compares its own byte range with every recorded range. Any entry whose bytes overlap the store is dropped. Later, a check operation names a register. If that register's entry is still present, the answer is a hit and the early value can be used. A miss means the load has to be issued again.

The table holds a fixed number of entries and any entry can take any register. If a register already has an entry, a new early load to that register overwrites it. If the table is full and the register has no entry, an entry is evicted in round-robin order, and a check of the evicted register then misses. A flush input empties the table.

All three request ports accept a request in every cycle, so there is no back-pressure and no ready signal. A request is taken on any rising clock edge where its valid is high. The check answer appears on `rsp_valid`/`rsp_hit` one cycle after the request.

Top module: `adv_load_table`

## Requirements
- R1: After reset, or after reset is applied again, the table is empty: every check misses and `rsp_valid` is low until a check is requested.
- R2: A check of a register with a live entry returns `rsp_valid`=1 and `rsp_hit`=1 in the cycle after the request. `rsp_valid` is high exactly in the cycles after a check request.
- R3: A check of a register that has never been recorded returns `rsp_hit`=0, which means a reload is needed.
- R4: The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes, and an access covers the bytes from its address up to address+bytes-1. A store whose byte range shares at least one byte with an entry's range removes that entry, so a later check misses.
- R5: A store whose byte range touches an entry's range only at the edge (adjacent, with no common byte) leaves that entry in place.
- R6: A new early load to a register that already has an entry replaces the older entry. After that, only the new address and size decide which stores remove it.
- R7: A check that hits leaves the entry unchanged, so a repeated check also hits.
- R8: The table holds 16 entries. After reset or a flush, entries fill in slot order. Once all slots are full, each new register evicts a slot in round-robin order starting at slot 0, and a check of the evicted register misses.
- R9: When a store and an early load arrive in the same cycle, the store's removals happen first. The new entry survives even if it overlaps the store, while older overlapping entries are removed.
- R10: The flush input removes every entry. An early load in the same cycle is recorded after the flush.
- R11: A check sees the table as it was before the updates of its own cycle. An early load and a check of the same register in the same cycle therefore miss, and a check in the next cycle hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_all | input | 1 | Remove every entry |
| ld_valid | input | 1 | Early load request valid |
| ld_reg | input | RW | Destination register of the early load |
| ld_addr | input | AW | Byte address of the early load |
| ld_size | input | 2 | Size code of the early load |
| st_valid | input | 1 | Store request valid |
| st_addr | input | AW | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Check request valid |
| chk_reg | input | RW | Register to check |
| rsp_valid | output | 1 | Check answer valid, one cycle after the request |
| rsp_hit | output | 1 | 1 = entry present, 0 = reload needed |

## Verification
The assertions check these rules on every cycle: the answer timing, that entries only disappear through a store or a flush, that at most one entry is added per cycle, that an early load always leaves a live entry, and that a flush without a load empties the table. Other behaviours need the bench's scenarios, which observe the answers to later checks. These are whether the right entry was removed by a byte overlap, the edge case where ranges are adjacent, the replacement of an entry for the same register, the ordering when a store, a flush and a load meet in one cycle, and the round-robin order of evictions.

// File: rtl/alat_pkg.sv
package alat_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input acc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/alat_overlap.sv
module alat_overlap
  import alat_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a_addr,
  input  logic [1:0]    a_size,
  input  logic [AW-1:0] b_addr,
  input  logic [1:0]    b_size,
  output logic          overlap
);
  localparam int EW = AW + 1;

  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo    = {1'b0, a_addr};
    b_lo    = {1'b0, b_addr};
    a_hi    = a_lo + EW'(size_bytes(acc_size_e'(a_size)));
    b_hi    = b_lo + EW'(size_bytes(acc_size_e'(b_size)));
    overlap = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/alat_victim.sv
module alat_victim #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         alloc,
  input  logic [N-1:0] free,
  input  logic [N-1:0] match,
  output logic [N-1:0] sel
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic          found;
  logic          evict;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    if (|match) begin
      sel = match;
    end else if (|free) begin
      for (int i = 0; i < N; i++) begin
        if (free[i] && !found) begin
          sel[i] = 1'b1;
          found  = 1'b1;
        end
      end
    end else begin
      sel = N'(1) << ptr_q;
    end
  end

  assign evict = alloc && !(|match) && !(|free);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (flush) begin
      ptr_q <= '0;
    end else if (evict) begin
      ptr_q <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/adv_load_table.sv
module adv_load_table #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_all,
  input  logic          ld_valid,
  input  logic [RW-1:0] ld_reg,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic          chk_valid,
  input  logic [RW-1:0] chk_reg,
  output logic          rsp_valid,
  output logic          rsp_hit
);
  logic [N-1:0]  vld_q;
  logic [RW-1:0] tag_q  [N];
  logic [AW-1:0] addr_q [N];
  logic [1:0]    size_q [N];

  logic [N-1:0] st_hit;
  logic [N-1:0] kill;
  logic [N-1:0] vld_post;
  logic [N-1:0] ld_match;
  logic [N-1:0] chk_match;
  logic [N-1:0] wr_sel;

  // per-entry comparators
  for (genvar g = 0; g < N; g++) begin : g_ent
    alat_overlap #(.AW(AW)) u_ovl (
      .a_addr (st_addr),
      .a_size (st_size),
      .b_addr (addr_q[g]),
      .b_size (size_q[g]),
      .overlap(st_hit[g])
    );
    assign kill[g]      = flush_all || (st_valid && st_hit[g]);
    assign vld_post[g]  = vld_q[g] && !kill[g];
    assign ld_match[g]  = vld_post[g] && (tag_q[g] == ld_reg);
    assign chk_match[g] = vld_q[g] && (tag_q[g] == chk_reg);
  end

  alat_victim #(.N(N)) u_vict (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush_all),
    .alloc(ld_valid),
    .free (~vld_post),
    .match(ld_match),
    .sel  (wr_sel)
  );

  // invalidations first, then the insert
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        vld_q[i] <= vld_post[i] || (ld_valid && wr_sel[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (ld_valid && wr_sel[i]) begin
        tag_q[i]  <= ld_reg;
        addr_q[i] <= ld_addr;
        size_q[i] <= ld_size;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_hit   <= chk_valid && (|chk_match);
    end
  end
endmodule

// File: rtl/alat_checks.sv
module alat_checks #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush_all,
  input logic         ld_valid,
  input logic         st_valid,
  input logic         chk_valid,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic [N-1:0] vld
);
  // R2: answer follows a request by one cycle
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);
  p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid);
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  // R7: entries vanish only through a store or a flush
  p_no_silent_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !flush_all) |=> $countones(vld) >= $past($countones(vld)));
  // R8: at most one entry added per cycle
  p_one_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(vld) <= $past($countones(vld)) + 1);
  // R9: an early load always leaves a live entry
  p_load_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> vld != '0);
  // R10: flush without a load empties the table
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !ld_valid) |=> vld == '0);
endmodule

bind adv_load_table alat_checks #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush_all(flush_all),
  .ld_valid (ld_valid),
  .st_valid (st_valid),
  .chk_valid(chk_valid),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .vld      (vld_q)
);

// File: tb/sim_adv_load_table.sv
module sim_adv_load_table;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_reg = '0;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        rsp_valid, rsp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  adv_load_table u0 (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
  );

  typedef struct packed {
    logic        fl;
    logic        iv;
    logic [6:0]  ir;
    logic [31:0] ia;
    logic [1:0]  isz;
    logic        sv;
    logic [31:0] sa;
    logic [1:0]  ssz;
    logic        cv;
    logic [6:0]  cr;
    logic        eh;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b0,4'd3},  // R3 empty
    '{1'b0,1'b1,7'd5, 32'h100,2'd3,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd2},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b1,4'd2},  // R2 hit
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b1,4'd7},  // R7 hit again
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd6, 1'b0,4'd3},  // R3 other reg
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h108,2'd3,1'b0,7'd0, 1'b0,4'd5},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b1,4'd5},  // R5 above
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'hFF, 2'd0,1'b0,7'd0, 1'b0,4'd5},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b1,4'd5},  // R5 below
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h107,2'd0,1'b0,7'd0, 1'b0,4'd4},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd5, 1'b0,4'd4},  // R4 last byte
    '{1'b0,1'b1,7'd7, 32'h200,2'd2,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd4},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h1FE,2'd1,1'b0,7'd0, 1'b0,4'd5},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd7, 1'b1,4'd5},  // R5 2-byte edge
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h1FC,2'd3,1'b0,7'd0, 1'b0,4'd4},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd7, 1'b0,4'd4},  // R4 8-byte store
    '{1'b0,1'b1,7'd8, 32'h300,2'd0,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd6},
    '{1'b0,1'b1,7'd8, 32'h400,2'd0,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd6},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h300,2'd0,1'b0,7'd0, 1'b0,4'd6},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd8, 1'b1,4'd6},  // R6 old addr ignored
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b1,32'h3FF,2'd1,1'b0,7'd0, 1'b0,4'd6},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd8, 1'b0,4'd6},  // R6 new addr tracked
    '{1'b0,1'b1,7'd9, 32'h500,2'd2,1'b1,32'h500,2'd2,1'b0,7'd0, 1'b0,4'd9},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd9, 1'b1,4'd9},  // R9 insert survives
    '{1'b0,1'b1,7'd10,32'h600,2'd0,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd9},
    '{1'b0,1'b1,7'd11,32'h600,2'd0,1'b1,32'h600,2'd0,1'b0,7'd0, 1'b0,4'd9},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd10,1'b0,4'd9},  // R9 older removed
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd11,1'b1,4'd9},  // R9 newer kept
    '{1'b0,1'b1,7'd12,32'h700,2'd0,1'b0,32'h0,  2'd0,1'b1,7'd12,1'b0,4'd11}, // R11 same cycle
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd12,1'b1,4'd11}, // R11 next cycle
    '{1'b1,1'b1,7'd13,32'h800,2'd0,1'b0,32'h0,  2'd0,1'b0,7'd0, 1'b0,4'd10},
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd9, 1'b0,4'd10}, // R10 cleared
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd11,1'b0,4'd10}, // R10 cleared
    '{1'b0,1'b0,7'd0, 32'h0,  2'd0,1'b0,32'h0,  2'd0,1'b1,7'd13,1'b1,4'd10}  // R10 load kept
  };

  task automatic check(input int rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %0b expected %0b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    flush_all = v.fl;
    ld_valid  = v.iv; ld_reg = v.ir; ld_addr = v.ia; ld_size = v.isz;
    st_valid  = v.sv; st_addr = v.sa; st_size = v.ssz;
    chk_valid = v.cv; chk_reg = v.cr;
    @(posedge clk);
    #1;
    if (v.cv) begin
      check(int'(v.rq), rsp_valid, 1'b1);
      check(int'(v.rq), rsp_hit, v.eh);
    end
  endtask

  function automatic vec_t load_v(input logic [6:0] r, input logic [31:0] a);
    vec_t v = '0;
    v.iv = 1'b1; v.ir = r; v.ia = a;
    return v;
  endfunction

  function automatic vec_t chk_v(input logic [6:0] r, input logic h, input logic [3:0] rq);
    vec_t v = '0;
    v.cv = 1'b1; v.cr = r; v.eh = h; v.rq = rq;
    return v;
  endfunction

  task automatic idle();
    vec_t v = '0;
    apply(v);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(1, rsp_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    check(1, rsp_valid, 1'b0);  // R2: no answer without a request

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
    end
    idle();
    check(2, rsp_valid, 1'b0);

    // R8: fill all 16 slots, then two round-robin evictions
    v = '0; v.fl = 1'b1;
    apply(v);
    for (int r = 20; r < 36; r++) begin
      apply(load_v(7'(r), 32'h1000 + 32'(r) * 32'h10));
    end
    apply(load_v(7'd36, 32'h2000));
    apply(load_v(7'd37, 32'h2100));
    apply(chk_v(7'd20, 1'b0, 4'd8));  // R8 slot 0 evicted
    apply(chk_v(7'd21, 1'b0, 4'd8));  // R8 slot 1 evicted
    apply(chk_v(7'd22, 1'b1, 4'd8));  // R8 slot 2 kept
    apply(chk_v(7'd35, 1'b1, 4'd8));
    apply(chk_v(7'd36, 1'b1, 4'd8));
    apply(chk_v(7'd37, 1'b1, 4'd8));

    // R1: reset applied again empties the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, rsp_valid, 1'b0);
    rst_n = 1'b1;
    apply(chk_v(7'd36, 1'b0, 4'd1));
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule